// File: doc/BRIEF.md
# Switch Change Interrupt Controller

This block watches a vector of switch contact states. When an enabled contact changes state, it raises an interrupt toward the host. The interrupt output is a drive-low enable for an open-drain line that several devices share. The line's actual level comes back in on a separate input.

The block takes part in serial accesses through the active-low chip select. On the falling edge of chip select, it captures its own pending interrupt into a status bit. The host reads that bit to find which device raised the interrupt. On the rising edge of chip select, the pending interrupt is released, unless another enabled contact changed while chip select was low.

The block also has a low-power mode. It enters that mode on request, but only when it is idle. It returns to normal mode on a chip-select falling edge, or on a falling edge of the shared interrupt line, so that one device can wake all the others.

Top module: `swchg_irq_ctrl`

## Requirements
- R1: In normal mode, a change on any switch whose enable bit is 1 makes `int_drive` 1 at the next clock edge.
- R2: A change on a switch whose enable bit is 0 does not set `int_drive`. The enable mask applies in the same cycle that the change is seen.
- R3: At a chip-select falling edge (`cs_n` going from 1 to 0), `int_stat` takes the value of this device's own pending interrupt. At all other times `int_stat` holds its value.
- R4: At a chip-select rising edge, `int_drive` returns to 0 if no enabled switch changed while `cs_n` was 0.
- R5: If an enabled switch changed while `cs_n` was 0, `int_drive` stays 1 through the chip-select rising edge.
- R6: When the shared line `int_line_n` is pulled low only by another device, this block captures `int_stat` = 0 and keeps `int_drive` at 0.
- R7: `sleep_req` = 1 moves `mode_normal` to 0 at the next edge only if `cs_n` = 1 and no interrupt is pending. Otherwise the request is ignored.
- R8: In sleep mode (`mode_normal` = 0), a chip-select falling edge sets `mode_normal` to 1 at the next edge.
- R9: In sleep mode, a falling edge on `int_line_n` sets `mode_normal` to 1 at the next edge.
- R10: Switch changes seen while in sleep mode never set `int_drive`, either during sleep or after the wake-up.
- R11: After reset, `int_drive` = 0, `int_stat` = 0 and `mode_normal` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_in | input | NUM_SW | Switch contact states, 1 = closed |
| sw_en | input | NUM_SW | Per-switch interrupt enable mask |
| cs_n | input | 1 | Serial chip select, active low |
| sleep_req | input | 1 | Request to enter sleep mode |
| int_line_n | input | 1 | Read-back level of the shared open-drain interrupt line |
| int_drive | output | 1 | 1 = pull the shared interrupt line low |
| int_stat | output | 1 | Interrupt status bit latched at the chip-select falling edge |
| mode_normal | output | 1 | 1 = normal mode, 0 = sleep mode |

## Verification
The main function is exercised with several contact patterns:
- A toggle on an enabled bit, which shows that detection works.
- A toggle on a masked bit, which shows that the mask is applied.
- A toggle that arrives during an access, which separates a suppressed release from a normal release.
- A pull on the shared line by another device only, which separates this device's own status from the line's level.

Sleep entry is tried both while an interrupt is pending and while chip select is low, to show that each condition blocks it. A switch toggle during sleep shows that stale changes are not reported after the wake-up. The wake-up is then triggered in turn by chip select and by the shared line.

// File: rtl/swchg_pkg.sv
package swchg_pkg;

  typedef enum logic {
    MODE_SLEEP  = 1'b0,
    MODE_NORMAL = 1'b1
  } swchg_mode_e;

  // Bits that differ from the previous sample and are enabled
  function automatic logic [63:0] diff_enabled(input logic [63:0] cur,
                                               input logic [63:0] prev,
                                               input logic [63:0] en);
    return (cur ^ prev) & en;
  endfunction

  // Pending interrupt survives a chip-select rising edge when a change hit the access
  function automatic logic release_allowed(input logic rise, input logic acc_chg);
    return rise & ~acc_chg;
  endfunction

  // Sleep may be entered only while idle and deselected
  function automatic logic sleep_allowed(input logic req, input logic cs_n,
                                         input logic pending, input logic chg);
    return req & cs_n & ~pending & ~chg;
  endfunction

endpackage

// File: rtl/swchg_edge.sv
module swchg_edge #(
  parameter bit RISING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sig;
  end

  generate
    if (RISING) begin : g_rise
      assign evt = ~prev_q & sig;
    end else begin : g_fall
      assign evt = prev_q & ~sig;
    end
  endgenerate
endmodule

// File: rtl/swchg_detect.sv
module swchg_detect
  import swchg_pkg::*;
#(
  parameter int NUM_SW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SW-1:0] sw_in,
  input  logic [NUM_SW-1:0] sw_en,
  input  logic              armed,
  output logic              change_evt
);
  localparam int PADW = 64 - NUM_SW;

  logic [NUM_SW-1:0] prev_q;
  logic [63:0]       diff_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sw_in;
  end

  assign diff_w = diff_enabled({{PADW{1'b0}}, sw_in},
                               {{PADW{1'b0}}, prev_q},
                               {{PADW{1'b0}}, sw_en});
  assign change_evt = armed & (|diff_w);
endmodule

// File: rtl/swchg_mode_fsm.sv
module swchg_mode_fsm
  import swchg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic cs_n,
  input  logic pending,
  input  logic change_evt,
  input  logic cs_fall,
  input  logic line_fall,
  output logic mode_normal
);
  swchg_mode_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MODE_NORMAL:
        if (sleep_allowed(sleep_req, cs_n, pending, change_evt)) state_d = MODE_SLEEP;
      MODE_SLEEP:
        if (cs_fall || line_fall) state_d = MODE_NORMAL;
      default: state_d = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MODE_NORMAL;
    else        state_q <= state_d;
  end

  assign mode_normal = (state_q == MODE_NORMAL);
endmodule

// File: rtl/swchg_int_core.sv
module swchg_int_core
  import swchg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic change_evt,
  input  logic cs_n,
  input  logic cs_fall,
  input  logic cs_rise,
  output logic pending,
  output logic stat,
  output logic acc_chg
);
  logic pend_q, stat_q, acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      stat_q <= 1'b0;
      acc_q  <= 1'b0;
    end else begin
      if (change_evt)                            pend_q <= 1'b1;
      else if (release_allowed(cs_rise, acc_q))  pend_q <= 1'b0;

      if (cs_fall) stat_q <= pend_q;

      if (cs_fall)                  acc_q <= change_evt;
      else if (change_evt && !cs_n) acc_q <= 1'b1;
    end
  end

  assign pending = pend_q;
  assign stat    = stat_q;
  assign acc_chg = acc_q;
endmodule

// File: rtl/swchg_irq_ctrl.sv
module swchg_irq_ctrl #(
  parameter int NUM_SW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SW-1:0] sw_in,
  input  logic [NUM_SW-1:0] sw_en,
  input  logic              cs_n,
  input  logic              sleep_req,
  input  logic              int_line_n,
  output logic              int_drive,
  output logic              int_stat,
  output logic              mode_normal
);
  logic cs_fall, cs_rise, line_fall;
  logic change_evt, pending, acc_chg;

  swchg_edge #(.RISING(1'b0)) u_cs_fall (
    .clk(clk), .rst_n(rst_n), .sig(cs_n), .evt(cs_fall));
  swchg_edge #(.RISING(1'b1)) u_cs_rise (
    .clk(clk), .rst_n(rst_n), .sig(cs_n), .evt(cs_rise));
  swchg_edge #(.RISING(1'b0)) u_line_fall (
    .clk(clk), .rst_n(rst_n), .sig(int_line_n), .evt(line_fall));

  swchg_detect #(.NUM_SW(NUM_SW)) u_detect (
    .clk(clk), .rst_n(rst_n), .sw_in(sw_in), .sw_en(sw_en),
    .armed(mode_normal), .change_evt(change_evt));

  swchg_mode_fsm u_mode (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cs_n(cs_n),
    .pending(pending), .change_evt(change_evt), .cs_fall(cs_fall),
    .line_fall(line_fall), .mode_normal(mode_normal));

  swchg_int_core u_core (
    .clk(clk), .rst_n(rst_n), .change_evt(change_evt), .cs_n(cs_n),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .pending(pending),
    .stat(int_stat), .acc_chg(acc_chg));

  assign int_drive = pending;
endmodule

// File: rtl/swchg_irq_checker.sv
module swchg_irq_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic cs_fall,
  input logic cs_rise,
  input logic change_evt,
  input logic acc_chg,
  input logic int_drive,
  input logic int_stat,
  input logic mode_normal
);
  assert_set_on_change_R1: assert property (@(posedge clk) disable iff (!rst_n)
    change_evt |=> int_drive);

  assert_stat_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> int_stat == $past(int_drive));

  assert_stat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(int_stat));

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_drive && cs_rise && !acc_chg && !change_evt) |=> !int_drive);

  assert_hold_on_access_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_drive && cs_rise && acc_chg) |=> int_drive);

  assert_sleep_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_normal) |-> ($past(cs_n) && !$past(int_drive)));

  assert_cs_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_normal && cs_fall) |=> mode_normal);

  assert_quiet_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_normal && !int_drive) |=> !int_drive);
endmodule

bind swchg_irq_ctrl swchg_irq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .change_evt(change_evt), .acc_chg(acc_chg), .int_drive(int_drive),
  .int_stat(int_stat), .mode_normal(mode_normal));

// File: tb/swchg_irq_ctrl_bench.sv
module swchg_irq_ctrl_bench;
  localparam int PERIOD = 10;
  localparam int N = 8;

  typedef struct {
    string tag;
    bit    drive;
    bit    stat;
    bit    mode;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] sw_in = '0;
  logic [N-1:0] sw_en = '1;
  logic         cs_n = 1'b1;
  logic         sleep_req = 1'b0;
  logic         ext_pull = 1'b0;
  logic         int_line_n;
  logic         int_drive, int_stat, mode_normal;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #(PERIOD/2) clk = ~clk;

  // Open-drain shared line: low if this device or another one pulls it
  assign int_line_n = ~(int_drive | ext_pull);

  swchg_irq_ctrl #(.NUM_SW(N)) u_swchg_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_in(sw_in), .sw_en(sw_en), .cs_n(cs_n),
    .sleep_req(sleep_req), .int_line_n(int_line_n), .int_drive(int_drive),
    .int_stat(int_stat), .mode_normal(mode_normal));

  // Driver: apply inputs at the falling edge, queue the result expected after the next rising edge
  task automatic step(input logic [N-1:0] sw, input logic [N-1:0] en,
                      input bit cs, input bit slp, input bit ext,
                      input bit chk, input string tag,
                      input bit ed, input bit es, input bit em);
    exp_t e;
    @(negedge clk);
    sw_in = sw; sw_en = en; cs_n = cs; sleep_req = slp; ext_pull = ext;
    if (chk) begin
      e.tag = tag; e.drive = ed; e.stat = es; e.mode = em;
      q.push_back(e);
    end
  endtask

  // Monitor: a quarter period after each rising edge
  always @(posedge clk) begin
    #(PERIOD/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if (int_drive !== e.drive || int_stat !== e.stat || mode_normal !== e.mode) begin
        mismatched++;
        $display("FAIL %s: got drive=%b stat=%b mode=%b, expected drive=%b stat=%b mode=%b",
                 e.tag, int_drive, int_stat, mode_normal, e.drive, e.stat, e.mode);
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //    sw      en      cs slp ext chk tag                          d  s  m
    step(8'h00, 8'hFF, 1, 0, 0, 1, "R11 reset state",             0, 0, 1);
    step(8'h01, 8'hFF, 1, 0, 0, 1, "R1 enabled change",           1, 0, 1);
    step(8'h01, 8'hFF, 1, 1, 0, 1, "R7 sleep refused pending",    1, 0, 1);
    step(8'h01, 8'hFF, 0, 0, 0, 1, "R3 status captured",          1, 1, 1);
    step(8'h01, 8'hFF, 1, 0, 0, 1, "R4 released at rise",         0, 1, 1);
    step(8'h00, 8'hFE, 1, 0, 0, 1, "R2 masked change",            0, 1, 1);
    step(8'h08, 8'hFE, 1, 0, 0, 1, "R1 second change",            1, 1, 1);
    step(8'h08, 8'hFE, 0, 0, 0, 1, "R3 capture pending",          1, 1, 1);
    step(8'h28, 8'hFE, 0, 0, 0, 1, "R5 change in access",         1, 1, 1);
    step(8'h28, 8'hFE, 1, 0, 0, 1, "R5 kept at rise",             1, 1, 1);
    step(8'h28, 8'hFE, 0, 0, 0, 0, "", 0, 0, 0);
    step(8'h28, 8'hFE, 1, 0, 0, 1, "R4 released clean access",    0, 1, 1);
    step(8'h28, 8'hFE, 1, 0, 1, 1, "R6 other device pulls",       0, 1, 1);
    step(8'h28, 8'hFE, 0, 0, 1, 1, "R6 status clear",             0, 0, 1);
    step(8'h28, 8'hFE, 1, 0, 1, 0, "", 0, 0, 0);
    step(8'h28, 8'hFE, 1, 0, 0, 0, "", 0, 0, 0);
    step(8'h28, 8'hFE, 0, 1, 0, 1, "R7 sleep refused cs low",     0, 0, 1);
    step(8'h28, 8'hFE, 1, 0, 0, 1, "R7 still normal",             0, 0, 1);
    step(8'h28, 8'hFE, 1, 1, 0, 1, "R7 sleep accepted",           0, 0, 0);
    step(8'h2A, 8'hFE, 1, 0, 0, 1, "R10 change in sleep",         0, 0, 0);
    step(8'h2A, 8'hFE, 0, 0, 0, 1, "R8 cs wake",                  0, 0, 1);
    step(8'h2A, 8'hFE, 1, 0, 0, 1, "R10 no stale report",         0, 0, 1);
    step(8'h2A, 8'hFE, 1, 1, 0, 1, "R7 sleep again",              0, 0, 0);
    step(8'h2A, 8'hFE, 1, 0, 0, 0, "", 0, 0, 0);
    step(8'h2A, 8'hFE, 1, 0, 1, 1, "R9 shared line wake",         0, 0, 1);
    step(8'h2A, 8'hFE, 1, 0, 0, 0, "", 0, 0, 0);
    step(8'h2B, 8'hFE, 1, 0, 0, 1, "R2 masked after wake",        0, 0, 1);
    step(8'h2F, 8'hFE, 1, 0, 0, 1, "R1 change after wake",        1, 0, 1);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule